// File: doc/BRIEF.md
# Leader-Pattern Gated Data Output

This block sits after a receiver's data slicer and decides when recovered serial data may reach the rest of the chip. It resynchronises the raw data bit and measures how long each level lasts, counted in ticks of a shared timebase. While idle it holds its output LOW and looks for a preamble of four timed levels: HIGH, then LOW, then HIGH, then LOW, each within a duration tolerance window. The preamble is never shown on the output. Once the preamble is matched, the data that follows is copied to the output for a fixed pass window. After that comes a rearm window in which data still flows and a new preamble restarts the whole window. If no new preamble arrives before the rearm window closes, the output drops back to LOW and the block resumes its search.

When leader detection is switched off, the preamble logic is bypassed. The data then flows whenever the carrier-sense flag is HIGH, and the output is LOW whenever that flag is LOW. When leader detection is on, the carrier-sense flag has no effect.

The gate state machine has the states SEARCH, PASS and RECHECK. Its transitions are: SEARCH to PASS on a match; PASS to RECHECK when the pass count is reached; RECHECK to PASS on a new match; RECHECK to SEARCH when the rearm limit is reached; and any state to SEARCH while detection is disabled. The preamble matcher has the states HUNT, HI1, LO1, HI2 and LO2. Its transitions are: HUNT to HI1 on a rising edge; each symbol state to the next on an edge that ends an in-window level; HI1 or HI2 to HUNT on a falling edge that ends an out-of-window level; LO1 to HI1 on a rising edge that ends an out-of-window level; LO2 to HUNT on a match; and LO2 to HI1 on a failed rising edge. The matcher is held in HUNT whenever the gate is in PASS or detection is disabled.

Top module: `leader_gate`

## Requirements
- R1: After synchronous reset, gated_bit is 0, the gate is in SEARCH and all counters are cleared.
- R2: With leader_en=1 and no preamble matched, gated_bit stays 0 whatever rx_bit does.
- R3: A match is a run of levels 1, 0, 1, 0 on the synchronised data, each lasting SYM_MIN to SYM_MAX ticks inclusive. The match is taken at the rising edge that ends the fourth level.
- R4: If any of the four levels is shorter than SYM_MIN ticks or longer than SYM_MAX ticks, there is no match and gated_bit stays 0.
- R5: The preamble levels never reach gated_bit. Once a match is taken, gated_bit equals rx_bit delayed by three clocks, starting with the level that follows the preamble.
- R6: The pass window lasts PASS_TICKS ticks from the match, and no preamble is searched for during it. A preamble sent inside the pass window does not extend the output period.
- R7: In the RECHECK window (PASS_TICKS to END_TICKS ticks after the match), data keeps flowing. A new match restarts the full window from that match.
- R8: If no new match arrives, gated_bit returns to 0 within six clocks after END_TICKS ticks have passed since the match, and the gate resumes SEARCH.
- R9: With leader_en=0, gated_bit is rx_bit delayed by three clocks while carrier_ok=1, and 0 while carrier_ok=0.
- R10: With leader_en=1, carrier_ok has no effect on gated_bit.
- R11: Durations are counted only on clocks with tick=1, not on every clock.
- R12: An out-of-window level that ends on a rising edge makes that rising edge the start of a new candidate preamble.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tick | input | 1 | Timebase strobe; one pulse is one duration unit |
| rx_bit | input | 1 | Raw demodulated data, asynchronous |
| leader_en | input | 1 | 1 enables preamble gating; 0 selects carrier-sense gating |
| carrier_ok | input | 1 | Carrier-sense flag, used only when leader_en=0 |
| gated_bit | output | 1 | Gated data output, registered |

## Verification
A matcher that takes the wrong step shows at the port as a missing or a spurious burst of data, three clocks after the rising edge that closes the preamble. This is why every duration combination around the tolerance limits is swept. A window counter that is wrong shows as an output that stays on too long or drops too early near the END_TICKS boundary. This includes a window wrongly extended by a preamble that arrives during PASS. A wrong gate state or a wrong carrier path shows within three clocks as a stuck-LOW or leaking output.

// File: rtl/leader_gate_pkg.sv
package leader_gate_pkg;

    typedef enum logic [2:0] {
        M_HUNT,
        M_HI1,
        M_LO1,
        M_HI2,
        M_LO2
    } match_st_t;

    typedef enum logic [1:0] {
        G_SEARCH,
        G_PASS,
        G_RECHECK
    } gate_st_t;

endpackage

// File: rtl/lg_sync.sv
module lg_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic lvl,
    output logic rise,
    output logic fall
);
    localparam int TOP = STAGES - 1;

    logic [STAGES-1:0] chain;
    logic              prev;

    always_ff @(posedge clk) begin
        if (rst) begin
            chain <= '0;
            prev  <= 1'b0;
        end else begin
            chain <= {chain[STAGES-2:0], din};
            prev  <= chain[TOP];
        end
    end

    assign lvl  = chain[TOP];
    assign rise = chain[TOP] & ~prev;
    assign fall = ~chain[TOP] & prev;

endmodule

// File: rtl/lg_run_meter.sv
module lg_run_meter #(
    parameter int SYM_MIN = 285,
    parameter int SYM_MAX = 315
) (
    input  logic clk,
    input  logic rst,
    input  logic tick,
    input  logic edge_seen,
    output logic sym_ok
);
    localparam int SAT = SYM_MAX + 1;
    localparam int RW  = $clog2(SAT + 1);
    localparam logic [RW-1:0] LO_V  = RW'(SYM_MIN);
    localparam logic [RW-1:0] HI_V  = RW'(SYM_MAX);
    localparam logic [RW-1:0] SAT_V = RW'(SAT);

    logic [RW-1:0] run_len;

    // run_len holds the tick count of the level that is ending on an edge cycle
    always_ff @(posedge clk) begin
        if (rst) begin
            run_len <= '0;
        end else if (edge_seen) begin
            run_len <= tick ? RW'(1) : '0;
        end else if (tick && run_len != SAT_V) begin
            run_len <= run_len + RW'(1);
        end
    end

    assign sym_ok = (run_len >= LO_V) && (run_len <= HI_V);

endmodule

// File: rtl/lg_matcher.sv
module lg_matcher
    import leader_gate_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      active,
    input  logic      rise,
    input  logic      fall,
    input  logic      sym_ok,
    output logic      hit,
    output match_st_t state
);
    match_st_t nxt;

    always_ff @(posedge clk) begin
        if (rst) state <= M_HUNT;
        else     state <= nxt;
    end

    always_comb begin
        nxt = state;
        if (!active) begin
            nxt = M_HUNT;
        end else begin
            unique case (state)
                M_HUNT: if (rise) nxt = M_HI1;
                M_HI1:  if (fall) nxt = sym_ok ? M_LO1 : M_HUNT;
                M_LO1:  if (rise) nxt = sym_ok ? M_HI2 : M_HI1;
                M_HI2:  if (fall) nxt = sym_ok ? M_LO2 : M_HUNT;
                M_LO2:  if (rise) nxt = sym_ok ? M_HUNT : M_HI1;
                default: nxt = M_HUNT;
            endcase
        end
    end

    always_comb begin
        hit = active && (state == M_LO2) && rise && sym_ok;
    end

endmodule

// File: rtl/lg_window.sv
module lg_window
    import leader_gate_pkg::*;
#(
    parameter int PASS_TICKS = 9800,
    parameter int END_TICKS  = 13000,
    parameter int WIN_W      = $clog2(END_TICKS + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic             leader_en,
    input  logic             carrier_ok,
    input  logic             hit,
    input  logic             lvl,
    output gate_st_t         state,
    output logic [WIN_W-1:0] win_count,
    output logic             gated_bit
);
    localparam logic [WIN_W-1:0] PASS_V = WIN_W'(PASS_TICKS);
    localparam logic [WIN_W-1:0] END_V  = WIN_W'(END_TICKS);

    gate_st_t nxt;
    logic     open_nxt;

    always_ff @(posedge clk) begin
        if (rst) state <= G_SEARCH;
        else     state <= nxt;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            win_count <= '0;
        end else if (hit || state == G_SEARCH) begin
            win_count <= '0;
        end else if (tick && win_count != END_V) begin
            win_count <= win_count + WIN_W'(1);
        end
    end

    always_comb begin
        nxt = state;
        if (!leader_en) begin
            nxt = G_SEARCH;
        end else begin
            unique case (state)
                G_SEARCH:  if (hit) nxt = G_PASS;
                G_PASS:    if (win_count >= PASS_V) nxt = G_RECHECK;
                G_RECHECK: begin
                    if (hit)                     nxt = G_PASS;
                    else if (win_count >= END_V) nxt = G_SEARCH;
                end
                default: nxt = G_SEARCH;
            endcase
        end
    end

    always_comb begin
        open_nxt = leader_en ? (nxt != G_SEARCH) : carrier_ok;
    end

    always_ff @(posedge clk) begin
        if (rst) gated_bit <= 1'b0;
        else     gated_bit <= open_nxt & lvl;
    end

endmodule

// File: rtl/leader_gate.sv
module leader_gate
    import leader_gate_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int SYM_MIN     = 285,
    parameter int SYM_MAX     = 315,
    parameter int PASS_TICKS  = 9800,
    parameter int END_TICKS   = 13000
) (
    input  logic clk,
    input  logic rst,
    input  logic tick,
    input  logic rx_bit,
    input  logic leader_en,
    input  logic carrier_ok,
    output logic gated_bit
);
    localparam int WIN_W = $clog2(END_TICKS + 1);

    logic             sync_lvl;
    logic             sync_rise;
    logic             sync_fall;
    logic             sym_ok;
    logic             leader_hit;
    logic             match_active;
    match_st_t        match_state;
    gate_st_t         gate_state;
    logic [WIN_W-1:0] win_count;

    lg_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst  (rst),
        .din  (rx_bit),
        .lvl  (sync_lvl),
        .rise (sync_rise),
        .fall (sync_fall)
    );

    lg_run_meter #(.SYM_MIN(SYM_MIN), .SYM_MAX(SYM_MAX)) u_meter (
        .clk       (clk),
        .rst       (rst),
        .tick      (tick),
        .edge_seen (sync_rise | sync_fall),
        .sym_ok    (sym_ok)
    );

    assign match_active = leader_en && (gate_state != G_PASS);

    lg_matcher u_match (
        .clk    (clk),
        .rst    (rst),
        .active (match_active),
        .rise   (sync_rise),
        .fall   (sync_fall),
        .sym_ok (sym_ok),
        .hit    (leader_hit),
        .state  (match_state)
    );

    lg_window #(
        .PASS_TICKS (PASS_TICKS),
        .END_TICKS  (END_TICKS),
        .WIN_W      (WIN_W)
    ) u_win (
        .clk        (clk),
        .rst        (rst),
        .tick       (tick),
        .leader_en  (leader_en),
        .carrier_ok (carrier_ok),
        .hit        (leader_hit),
        .lvl        (sync_lvl),
        .state      (gate_state),
        .win_count  (win_count),
        .gated_bit  (gated_bit)
    );

endmodule

// File: rtl/leader_gate_chk.sv
module leader_gate_chk
    import leader_gate_pkg::*;
#(
    parameter int END_TICKS = 13000,
    parameter int WIN_W     = 14
) (
    input logic             clk,
    input logic             rst,
    input logic             leader_en,
    input logic             carrier_ok,
    input logic             gated_bit,
    input logic             sync_lvl,
    input logic             leader_hit,
    input gate_st_t         gate_state,
    input match_st_t        match_state,
    input logic [WIN_W-1:0] win_count
);
    localparam logic [WIN_W-1:0] END_V = WIN_W'(END_TICKS);

    AST_SEARCH_QUIET: assert property (@(posedge clk) disable iff (rst)
        ($past(leader_en) && gate_state == G_SEARCH) |-> !gated_bit); // R2

    AST_CS_BLOCK: assert property (@(posedge clk) disable iff (rst)
        (!$past(leader_en) && !$past(carrier_ok)) |-> !gated_bit); // R9

    AST_PASS_COPY: assert property (@(posedge clk) disable iff (rst)
        ($past(leader_en) && gate_state != G_SEARCH) |-> gated_bit == $past(sync_lvl)); // R5

    AST_ENTRY_NEEDS_HIT: assert property (@(posedge clk) disable iff (rst)
        (gate_state == G_PASS && $past(gate_state) != G_PASS) |-> $past(leader_hit)); // R3

    AST_MATCHER_IDLE: assert property (@(posedge clk) disable iff (rst)
        (gate_state == G_PASS && $past(gate_state) == G_PASS) |-> match_state == M_HUNT); // R6

    AST_RECHECK_ORDER: assert property (@(posedge clk) disable iff (rst)
        (gate_state == G_RECHECK && $past(gate_state) != G_RECHECK) |-> $past(gate_state) == G_PASS); // R7

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        win_count <= END_V); // R8

endmodule

bind leader_gate leader_gate_chk #(.END_TICKS(END_TICKS), .WIN_W(WIN_W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .leader_en   (leader_en),
    .carrier_ok  (carrier_ok),
    .gated_bit   (gated_bit),
    .sync_lvl    (sync_lvl),
    .leader_hit  (leader_hit),
    .gate_state  (gate_state),
    .match_state (match_state),
    .win_count   (win_count)
);

// File: tb/leader_gate_tb.sv
module leader_gate_tb;
    localparam int SMIN = 3;
    localparam int SMAX = 5;
    localparam int PW   = 40;
    localparam int EW   = 80;

    localparam int NOCHK = 0;
    localparam int EXP0  = 1;
    localparam int EXPH  = 2;
    localparam int EXP1  = 3;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic tick = 1'b1;
    logic rx_bit = 1'b0;
    logic leader_en = 1'b1;
    logic carrier_ok = 1'b1;
    logic gated_bit;

    logic [2:0] hist = 3'b000;
    bit alt = 1'b0;
    int n_chk = 0;
    int n_fail = 0;

    always #2 clk = ~clk;

    leader_gate #(
        .SYNC_STAGES (2),
        .SYM_MIN     (SMIN),
        .SYM_MAX     (SMAX),
        .PASS_TICKS  (PW),
        .END_TICKS   (EW)
    ) u_dut (
        .clk        (clk),
        .rst        (rst),
        .tick       (tick),
        .rx_bit     (rx_bit),
        .leader_en  (leader_en),
        .carrier_ok (carrier_ok),
        .gated_bit  (gated_bit)
    );

    task automatic chk_eq(input string req, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: gated_bit=%b expected %b at %0t", req, act, exp, $time);
        end
    endtask

    // one clock: check the output at the negedge, then drive the next input
    task automatic step(input logic v, input int mode, input string req);
        @(negedge clk);
        case (mode)
            EXP0: chk_eq(req, gated_bit, 1'b0);
            EXP1: chk_eq(req, gated_bit, 1'b1);
            EXPH: chk_eq(req, gated_bit, hist[2]);
            default: ;
        endcase
        hist   = {hist[1:0], v};
        rx_bit = v;
        tick   = alt ? ~tick : 1'b1;
    endtask

    task automatic level(input logic v, input int n, input int mode, input string req);
        for (int i = 0; i < n; i++) step(v, mode, req);
    endtask

    task automatic leader(input int d1, input int d2, input int d3, input int d4,
                          input int mode, input string req);
        level(1'b1, d1, mode, req);
        level(1'b0, d2, mode, req);
        level(1'b1, d3, mode, req);
        level(1'b0, d4, mode, req);
    endtask

    task automatic do_reset();
        rst = 1'b1;
        level(1'b0, 3, NOCHK, "");
        rst = 1'b0;
    endtask

    task automatic finish_run();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: run did not complete");
        finish_run();
    end

    initial begin
        logic v;
        int mode;
        string req;

        // R1: reset state
        do_reset();
        level(1'b0, 3, EXP0, "R1 reset output");

        // R2: irregular pulses, no valid preamble, output stays low
        for (int i = 0; i < 40; i++) begin
            level(1'b1, (i % 3 == 0) ? 1 : 7, EXP0, "R2 search quiet");
            level(1'b0, (i % 2 == 0) ? 2 : 7, EXP0, "R2 search quiet");
        end

        // R5, R6, R8: copy after match, preamble inside PASS ignored, window end
        do_reset();
        level(1'b0, 3, NOCHK, "");
        leader(4, 4, 4, 4, EXP0, "R5 preamble hidden");
        for (int i = 0; i <= EW + 8; i++) begin
            if (i < 5)       v = 1'b1;
            else if (i < 21) v = (((i - 5) / 4) % 2 == 0) ? 1'b1 : 1'b0;
            else             v = 1'b1;
            if (i < 30)            begin mode = EXPH; req = "R5 data copy"; end
            else if (i == EW)      begin mode = EXP1; req = "R6 window still open"; end
            else if (i >= EW + 6)  begin mode = EXP0; req = "R8 window closed, R6 not extended"; end
            else                   begin mode = NOCHK; req = ""; end
            step(v, mode, req);
        end

        // R7: new preamble in RECHECK restarts the window
        do_reset();
        level(1'b0, 3, NOCHK, "");
        leader(4, 4, 4, 4, NOCHK, "");
        for (int i = 0; i <= 152; i++) begin
            if (i < PW + 4)      v = 1'b1;
            else if (i < 48)     v = 1'b0;
            else if (i < 64)     v = (((i - 48) / 4) % 2 == 0) ? 1'b1 : 1'b0;
            else                 v = 1'b1;
            if (i == EW + 6)           begin mode = EXP1; req = "R7 restart past old end"; end
            else if (i == 64 + EW)     begin mode = EXP1; req = "R7 restarted window open"; end
            else if (i >= 64 + EW + 6) begin mode = EXP0; req = "R7 restarted window closed"; end
            else                       begin mode = NOCHK; req = ""; end
            step(v, mode, req);
        end

        // R9: carrier-sense gating with leader detection disabled
        do_reset();
        leader_en = 1'b0;
        for (int blk = 0; blk < 6; blk++) begin
            carrier_ok = blk[0];
            for (int i = 0; i < 12; i++) begin
                v = (((i * 5 + blk) % 7) < 3) ? 1'b1 : 1'b0;
                if (i < 3)          step(v, NOCHK, "");
                else if (carrier_ok) step(v, EXPH, "R9 carrier pass");
                else                 step(v, EXP0, "R9 carrier block");
            end
        end
        leader_en  = 1'b1;
        carrier_ok = 1'b1;

        // R10: carrier flag low is ignored when leader detection is on
        do_reset();
        carrier_ok = 1'b0;
        level(1'b0, 3, NOCHK, "");
        leader(4, 4, 4, 4, EXP0, "R10 preamble hidden");
        level(1'b1, 3, NOCHK, "");
        level(1'b1, 5, EXP1, "R10 carrier ignored");
        carrier_ok = 1'b1;

        // R11: durations counted in ticks (tick every other clock)
        alt = 1'b1;
        do_reset();
        level(1'b0, 4, NOCHK, "");
        leader(8, 8, 8, 8, NOCHK, "");
        level(1'b1, 4, NOCHK, "");
        level(1'b1, 4, EXP1, "R11 eight clocks are four ticks");
        do_reset();
        level(1'b0, 4, NOCHK, "");
        leader(4, 4, 4, 4, NOCHK, "");
        level(1'b1, 8, EXP0, "R11 four clocks are two ticks");
        alt  = 1'b0;
        tick = 1'b1;

        // R12: failed level ending on a rising edge starts a new candidate
        do_reset();
        level(1'b0, 3, NOCHK, "");
        level(1'b1, 4, NOCHK, "");
        level(1'b0, 8, NOCHK, "");
        leader(4, 4, 4, 4, NOCHK, "");
        level(1'b1, 3, NOCHK, "");
        level(1'b1, 3, EXP1, "R12 restart on failing rising edge");

        // R3, R4: sweep all four symbol durations across the tolerance limits
        for (int a = 2; a <= 6; a++)
            for (int b = 2; b <= 6; b++)
                for (int c = 2; c <= 6; c++)
                    for (int d = 2; d <= 6; d++) begin
                        bit good;
                        good = (a >= SMIN && a <= SMAX) && (b >= SMIN && b <= SMAX) &&
                               (c >= SMIN && c <= SMAX) && (d >= SMIN && d <= SMAX);
                        do_reset();
                        level(1'b0, 3, NOCHK, "");
                        leader(a, b, c, d, NOCHK, "");
                        level(1'b1, 5, NOCHK, "");
                        if (good) step(1'b1, EXP1, "R3 in-window preamble matched");
                        else      step(1'b1, EXP0, "R4 out-of-window preamble rejected");
                    end

        finish_run();
    end

endmodule